// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI host that runs one flash command per trigger. Software writes an opcode into its own register and the two byte counts, places any payload bytes after the opcode into a shared byte FIFO, and then writes the start bit. The engine pulls chip select low, shifts the opcode out and then the payload bytes, MSB first, in SPI mode 0. It then clocks in the requested number of response bytes. It writes them back into the same FIFO, starting at the entry right after the last payload byte.

The SCK rate comes from a 4-bit speed code. That code maps onto fixed divide ratios of a 200 MHz reference clock. Software polls a busy flag in the status word and then reads the response from the FIFO window. A request whose payload plus response does not fit in the FIFO is refused: no frame is sent, and a sticky error flag is raised.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and both status bytes (0x08 and 0x0B) read 0.
- R2: A frame carries 8*(1+tx+rx) SCK pulses. The opcode (register 0x00) goes first, followed by FIFO bytes 0..tx-1, each MSB first. MOSI never changes while SCK is high.
- R3: Response byte j, sampled from MISO on rising SCK edges, is stored at FIFO index tx+j. FIFO bytes 0..tx-1 are left unchanged.
- R4: From the clock edge that accepts a start until the frame ends, bit 7 of status byte 0x0B (bit 31 of the status word) reads 1. spi_cs_n is low exactly while that flag is set.
- R5: If tx (register 0x01) plus rx (register 0x02) exceeds 71, a start sets bit 0 of status byte 0x08, and no frame is sent. A sum of exactly 71 is accepted.
- R6: The error flag stays set, including across later valid transfers, until 1 is written to bit 0 of control register 0x04.
- R7: Writing the start bit (bit 7 of 0x04) while busy has no effect. The running frame completes once, unchanged.
- R8: The speed code (low 4 bits of 0x03) sets the SCK period in reference cycles: 0 gives 3, 1 gives 6, 2 gives 9, 3 gives 12, 4 gives 2, 5 gives 250, and every other code gives 6.
- R9: SCK stays low while spi_cs_n is high. The first SCK rise comes 1+P-floor(P/2) reference cycles after spi_cs_n falls, where P is the period. spi_cs_n rises one cycle after the last SCK fall.
- R10: FIFO byte i is read and written at address 0x80+i for i from 0 to 70. Registers 0x00 to 0x03 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A wrong byte or bit counter shows up at the pins as the wrong number of SCK pulses. At the FIFO window it shows up as response bytes that are shifted or that overwrite the payload. Both are visible as soon as busy drops. A wrong divider or a wrong phase counter shows up within the first two SCK rises, as a wrong period or a wrong chip-select setup time. A fault in the length guard, or in the error flag's hold and clear, is visible one cycle after the start write: either chip select falls when it should not, or the status byte shows the wrong flag.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_SETUP,
      ENG_SHIFT,
      ENG_HOLD
   } eng_state_t;

   // SCK rate in kHz for a speed code; unlisted codes fall back to 33.33 MHz
   function automatic int unsigned rate_khz(input logic [3:0] code);
      int unsigned r;
      case (code)
         4'd0:    r = 66666;
         4'd1:    r = 33333;
         4'd2:    r = 22222;
         4'd3:    r = 16666;
         4'd4:    r = 100000;
         4'd5:    r = 800;
         default: r = 33333;
      endcase
      return r;
   endfunction

   // SCK period in reference cycles
   function automatic int unsigned sck_div(input logic [3:0] code, input int unsigned ref_khz);
      return ref_khz / rate_khz(code);
   endfunction

endpackage

// File: rtl/spi_sck_gen.sv
`timescale 1ns/1ps
module spi_sck_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sck,
   output logic             sample_now,
   output logic             bit_end
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] low_len;

   // low phase takes the larger half of an odd period
   assign low_len    = div - (div >> 1);
   assign sample_now = run && ((cnt + ONE) == low_len);
   assign bit_end    = run && (cnt == (div - ONE));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (bit_end) begin
         cnt <= '0;
         sck <= 1'b0;
      end else begin
         cnt <= cnt + ONE;
         if (sample_now) sck <= 1'b1;
      end
   end
endmodule

// File: rtl/spi_fifo_mem.sv
`timescale 1ns/1ps
module spi_fifo_mem #(
   parameter int DEPTH = 71,
   parameter int AW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_widx,
   input  logic [7:0]    bus_wdata,
   input  logic [AW-1:0] bus_ridx,
   output logic [7:0]    bus_rdata,
   input  logic          eng_we,
   input  logic [AW-1:0] eng_widx,
   input  logic [7:0]    eng_wdata,
   input  logic [AW-1:0] eng_ridx,
   output logic [7:0]    eng_rdata
);
   logic [7:0] mem [DEPTH];

   assign bus_rdata = (32'(bus_ridx) < DEPTH) ? mem[bus_ridx] : 8'h00;
   assign eng_rdata = (32'(eng_ridx) < DEPTH) ? mem[eng_ridx] : 8'h00;

   // engine write is issued last so it wins on a shared index
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else begin
         if (bus_we && (32'(bus_widx) < DEPTH)) mem[bus_widx] <= bus_wdata;
         if (eng_we && (32'(eng_widx) < DEPTH)) mem[eng_widx] <= eng_wdata;
      end
   end
endmodule

// File: rtl/spi_cmd_shifter.sv
`timescale 1ns/1ps
module spi_cmd_shifter
   import spi_cmd_pkg::*;
#(
   parameter int AW    = 7,
   parameter int CNT_W = 7,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       opcode,
   input  logic [CNT_W-1:0] tx_len,
   input  logic [CNT_W-1:0] rx_len,
   input  logic [DIV_W-1:0] div_in,
   input  logic             miso,
   input  logic             sample_now,
   input  logic             bit_end,
   input  logic [7:0]       fifo_rdata,
   output logic             busy,
   output logic             run,
   output logic             cs_n,
   output logic             mosi,
   output logic [DIV_W-1:0] div_q,
   output logic [AW-1:0]    fifo_ridx,
   output logic             fifo_we,
   output logic [AW-1:0]    fifo_widx,
   output logic [7:0]       fifo_wdata
);
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   eng_state_t       state;
   logic [CNT_W-1:0] byte_idx;
   logic [CNT_W-1:0] last_idx;
   logic [CNT_W-1:0] tx_q;
   logic [2:0]       bit_cnt;
   logic [7:0]       sreg;
   logic             rx_bit;
   logic             byte_done;
   logic             in_rx;

   assign busy      = (state != ENG_IDLE);
   assign run       = (state == ENG_SHIFT);
   assign mosi      = sreg[7];
   assign byte_done = bit_end && (bit_cnt == 3'd7);
   assign in_rx     = (byte_idx > tx_q);

   // frame byte k (k>=1) maps to FIFO index k-1 in both directions
   assign fifo_ridx  = AW'(byte_idx);
   assign fifo_we    = byte_done && in_rx;
   assign fifo_widx  = AW'(byte_idx - C_ONE);
   assign fifo_wdata = {sreg[6:0], rx_bit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         cs_n     <= 1'b1;
         byte_idx <= '0;
         last_idx <= '0;
         tx_q     <= '0;
         bit_cnt  <= '0;
         sreg     <= '0;
         rx_bit   <= 1'b0;
         div_q    <= '0;
      end else begin
         case (state)
            ENG_IDLE: if (start) begin
               state    <= ENG_SETUP;
               cs_n     <= 1'b0;
               sreg     <= opcode;
               tx_q     <= tx_len;
               last_idx <= tx_len + rx_len;
               byte_idx <= '0;
               bit_cnt  <= '0;
               div_q    <= div_in;
            end
            ENG_SETUP: state <= ENG_SHIFT;
            ENG_SHIFT: begin
               if (sample_now) rx_bit <= miso;
               if (bit_end) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) begin
                     if (byte_idx == last_idx) begin
                        state <= ENG_HOLD;
                     end else begin
                        byte_idx <= byte_idx + C_ONE;
                        sreg     <= (byte_idx < tx_q) ? fifo_rdata : 8'h00;
                     end
                  end else begin
                     sreg <= {sreg[6:0], rx_bit};
                  end
               end
            end
            ENG_HOLD: begin
               state <= ENG_IDLE;
               cs_n  <= 1'b1;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH     = 71,
   parameter int ADDR_W    = 8,
   parameter int FIFO_BASE = 128,
   parameter int REF_KHZ   = 200000,
   parameter int DIV_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 2);
   localparam logic [ADDR_W-1:0] A_OPC  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_TXC  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_RXC  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_SPD  = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_ST0  = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_ST3  = ADDR_W'(11);

   if (FIFO_BASE + DEPTH > (1 << ADDR_W)) begin : g_bad_window
      $error("FIFO window does not fit the address space");
   end
   if (DEPTH > 255 || DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must lie in 1..255 for 8-bit count registers");
   end
   if (REF_KHZ / 800 >= (1 << DIV_W) || REF_KHZ / 100000 < 2) begin : g_bad_div
      $error("DIV_W or REF_KHZ cannot express the speed table");
   end

   logic [7:0] opcode_q, txc_q, rxc_q;
   logic [3:0] speed_q;
   logic       err_q;
   logic       busy, run, sample_now, bit_end;
   logic       in_fifo, ctrl_wr, go, fits, start;
   logic [AW-1:0]    bus_idx;
   logic [7:0]       bus_fifo_rdata, eng_rdata, eng_wdata;
   logic [AW-1:0]    eng_ridx, eng_widx;
   logic             eng_we;
   logic [DIV_W-1:0] div_sel, div_q;

   assign in_fifo = (32'(reg_addr) >= FIFO_BASE) && (32'(reg_addr) < FIFO_BASE + DEPTH);
   assign bus_idx = AW'(32'(reg_addr) - FIFO_BASE);
   assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
   assign go      = ctrl_wr && reg_wdata[7];
   assign fits    = ({1'b0, txc_q} + {1'b0, rxc_q}) <= 9'(DEPTH);
   assign start   = go && !busy && fits;
   assign div_sel = DIV_W'(sck_div(speed_q, REF_KHZ));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opcode_q <= '0;
         txc_q    <= '0;
         rxc_q    <= '0;
         speed_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         if (reg_we && reg_addr == A_OPC) opcode_q <= reg_wdata;
         if (reg_we && reg_addr == A_TXC) txc_q    <= reg_wdata;
         if (reg_we && reg_addr == A_RXC) rxc_q    <= reg_wdata;
         if (reg_we && reg_addr == A_SPD) speed_q  <= reg_wdata[3:0];
         if (go && !busy && !fits)        err_q    <= 1'b1;
         else if (ctrl_wr && reg_wdata[0]) err_q   <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = 8'h00;
      if (in_fifo) reg_rdata = bus_fifo_rdata;
      else begin
         case (reg_addr)
            A_OPC:   reg_rdata = opcode_q;
            A_TXC:   reg_rdata = txc_q;
            A_RXC:   reg_rdata = rxc_q;
            A_SPD:   reg_rdata = {4'h0, speed_q};
            A_ST0:   reg_rdata = {7'h00, err_q};
            A_ST3:   reg_rdata = {busy, 7'h00};
            default: reg_rdata = 8'h00;
         endcase
      end
   end

   spi_fifo_mem #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (reg_we && in_fifo),
      .bus_widx  (bus_idx),
      .bus_wdata (reg_wdata),
      .bus_ridx  (bus_idx),
      .bus_rdata (bus_fifo_rdata),
      .eng_we    (eng_we),
      .eng_widx  (eng_widx),
      .eng_wdata (eng_wdata),
      .eng_ridx  (eng_ridx),
      .eng_rdata (eng_rdata)
   );

   spi_cmd_shifter #(.AW(AW), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .opcode     (opcode_q),
      .tx_len     (CNT_W'(txc_q)),
      .rx_len     (CNT_W'(rxc_q)),
      .div_in     (div_sel),
      .miso       (spi_miso),
      .sample_now (sample_now),
      .bit_end    (bit_end),
      .fifo_rdata (eng_rdata),
      .busy       (busy),
      .run        (run),
      .cs_n       (spi_cs_n),
      .mosi       (spi_mosi),
      .div_q      (div_q),
      .fifo_ridx  (eng_ridx),
      .fifo_we    (eng_we),
      .fifo_widx  (eng_widx),
      .fifo_wdata (eng_wdata)
   );

   spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .div        (div_q),
      .sck        (spi_sck),
      .sample_now (sample_now),
      .bit_end    (bit_end)
   );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
`timescale 1ns/1ps
module spi_cmd_engine_chk #(
   parameter int DEPTH  = 71,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              busy,
   input logic              err,
   input logic [7:0]        txc,
   input logic [7:0]        rxc,
   input logic              cs_n,
   input logic              sck,
   input logic              mosi
);
   logic go_wr, clr_wr, req_fits;
   assign go_wr    = reg_we && (reg_addr == CTRL_ADDR) && reg_wdata[7];
   assign clr_wr   = reg_we && (reg_addr == CTRL_ADDR) && reg_wdata[0];
   assign req_fits = ({1'b0, txc} + {1'b0, rxc}) <= 9'(DEPTH);

   p_sck_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   p_select_tracks_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !cs_n);

   p_mosi_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   p_start_accepted_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr && !busy && req_fits) |=> busy);

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr && !busy && !req_fits) |=> (!busy && err));

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr_wr) |=> err);

   p_busy_trigger_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (go_wr && busy && !cs_n && sck) |=> !cs_n);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(
   .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CTRL_ADDR(A_CTRL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .busy      (busy),
   .err       (err_q),
   .txc       (txc_q),
   .rxc       (rxc_q),
   .cs_n      (spi_cs_n),
   .sck       (spi_sck),
   .mosi      (spi_mosi)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
   localparam logic [7:0] A_OPC = 8'h00, A_TXC = 8'h01, A_RXC = 8'h02, A_SPD = 8'h03;
   localparam logic [7:0] A_CTRL = 8'h04, A_ST0 = 8'h08, A_ST3 = 8'h0B, FB = 8'h80;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
   logic spi_sck, spi_cs_n, spi_mosi, spi_miso = 1'b0;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   spi_cmd_engine u_spi_cmd_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // ---- device model: mode 0, answers a known byte stream on MISO ----
   logic [7:0] slave_seed = 8'h00;
   logic [7:0] mosi_byte [0:79];
   int bitk = 0, rise_n = 0, cs_falls = 0;
   realtime t_cs_fall, t_cs_rise, t_r1, t_r2, t_last_fall;

   function automatic logic [7:0] spat(input int i);
      return slave_seed ^ 8'(i * 29 + 1);
   endfunction

   function automatic logic sbit(input int k);
      logic [7:0] b;
      b = spat(k / 8);
      return b[7 - (k % 8)];
   endfunction

   always @(negedge spi_cs_n) begin
      bitk = 0; rise_n = 0; cs_falls++;
      t_cs_fall = $realtime;
      spi_miso = sbit(0);
   end
   always @(posedge spi_cs_n) t_cs_rise = $realtime;
   always @(posedge spi_sck) if (!spi_cs_n && bitk < 640) begin
      mosi_byte[bitk / 8] = {mosi_byte[bitk / 8][6:0], spi_mosi};
      bitk++;
      if (rise_n == 0) t_r1 = $realtime;
      if (rise_n == 1) t_r2 = $realtime;
      rise_n++;
   end
   always @(negedge spi_sck) if (spi_cs_n === 1'b0) begin
      t_last_fall = $realtime;
      spi_miso = sbit(bitk);
   end

   // ---- helpers ----
   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
   endtask

   logic [7:0] e_op;
   int e_tx, e_rx, falls0;

   function automatic logic [7:0] txd(input int i);
      return e_op ^ 8'h5A ^ 8'(i * 7);
   endfunction

   task automatic load(input logic [7:0] op, input int tx, input int rx,
                       input logic [3:0] spd, input logic [7:0] seed);
      e_op = op; e_tx = tx; e_rx = rx; slave_seed = seed;
      for (int i = 0; i < tx && i < 71; i++) bus_write(FB + 8'(i), txd(i));
      bus_write(A_OPC, op);
      bus_write(A_TXC, 8'(tx));
      bus_write(A_RXC, 8'(rx));
      bus_write(A_SPD, {4'h0, spd});
      falls0 = cs_falls;
   endtask

   task automatic wait_idle(input string tag);
      logic [7:0] s;
      int n = 0;
      s = 8'h80;
      while (s[7] && n < 60000) begin
         bus_read(A_ST3, s);
         n++;
      end
      chk({31'd0, s[7]}, 32'd0, {tag, " R4 busy clears"});
   endtask

   task automatic verify(input string tag);
      logic [7:0] d;
      chk(32'(cs_falls - falls0), 32'd1, {tag, " R7 single frame"});
      chk(32'(bitk), 32'(8 * (1 + e_tx + e_rx)), {tag, " R2 pulse count"});
      chk({24'd0, mosi_byte[0]}, {24'd0, e_op}, {tag, " R2 opcode first"});
      for (int i = 0; i < e_tx; i++)
         chk({24'd0, mosi_byte[1 + i]}, {24'd0, txd(i)}, {tag, " R2 payload byte"});
      for (int i = 0; i < e_tx; i++) begin
         bus_read(FB + 8'(i), d);
         chk({24'd0, d}, {24'd0, txd(i)}, {tag, " R3 payload kept"});
      end
      for (int j = 0; j < e_rx; j++) begin
         bus_read(FB + 8'(e_tx + j), d);
         chk({24'd0, d}, {24'd0, spat(1 + e_tx + j)}, {tag, " R3 response byte"});
      end
   endtask

   task automatic do_xfer(input logic [7:0] op, input int tx, input int rx,
                          input logic [3:0] spd, input logic [7:0] seed, input string tag);
      logic [7:0] s;
      load(op, tx, rx, spd, seed);
      bus_write(A_CTRL, 8'h80);
      bus_read(A_ST3, s);
      chk({31'd0, s[7]}, 32'd1, {tag, " R4 busy set"});
      chk({31'd0, spi_cs_n}, 32'd0, {tag, " R4 select low while busy"});
      wait_idle(tag);
      chk({31'd0, spi_cs_n}, 32'd1, {tag, " R4 select released"});
      verify(tag);
   endtask

   // ---- scenarios ----
   task automatic t_reset();
      logic [7:0] d;
      chk({31'd0, spi_cs_n}, 32'd1, "R1 cs_n idle");
      chk({31'd0, spi_sck}, 32'd0, "R1 sck idle");
      bus_read(A_ST0, d); chk({24'd0, d}, 32'd0, "R1 status low byte");
      bus_read(A_ST3, d); chk({24'd0, d}, 32'd0, "R1 status high byte");
   endtask

   task automatic t_regmap();
      logic [7:0] d;
      bus_write(A_OPC, 8'hC3); bus_read(A_OPC, d); chk({24'd0, d}, 32'hC3, "R10 opcode readback");
      bus_write(A_SPD, 8'h07); bus_read(A_SPD, d); chk({24'd0, d}, 32'h07, "R10 speed readback");
      bus_write(FB, 8'h11); bus_read(FB, d); chk({24'd0, d}, 32'h11, "R10 FIFO first entry");
      bus_write(FB + 8'd70, 8'h9E); bus_read(FB + 8'd70, d); chk({24'd0, d}, 32'h9E, "R10 FIFO last entry");
   endtask

   task automatic t_speed(input logic [3:0] code, input int per);
      do_xfer(8'hB1 ^ {4'h0, code}, 0, 0, code, 8'h42, "speed");
      chk(32'(int'((t_r2 - t_r1) / 5.0)), 32'(per), "R8 SCK period");
      chk(32'(int'((t_r1 - t_cs_fall) / 5.0)), 32'(1 + per - per / 2), "R9 select to first rise");
      chk(32'(int'((t_cs_rise - t_last_fall) / 5.0)), 32'd1, "R9 last fall to release");
   endtask

   task automatic t_overflow();
      logic [7:0] d;
      int f;
      bus_write(A_TXC, 8'd4);
      bus_write(A_RXC, 8'd68);
      f = cs_falls;
      bus_write(A_CTRL, 8'h80);
      repeat (4) @(negedge clk);
      bus_read(A_ST0, d); chk({24'd0, d}, 32'h01, "R5 error on 72 bytes");
      bus_read(A_ST3, d); chk({24'd0, d}, 32'h00, "R5 no busy on overflow");
      chk(32'(cs_falls - f), 32'd0, "R5 no frame on overflow");
      do_xfer(8'h05, 0, 1, 4'd4, 8'h19, "after overflow");
      bus_read(A_ST0, d); chk({24'd0, d}, 32'h01, "R6 error kept over valid transfer");
      bus_write(A_CTRL, 8'h01);
      bus_read(A_ST0, d); chk({24'd0, d}, 32'h00, "R6 error cleared");
      bus_write(A_TXC, 8'd72);
      bus_write(A_RXC, 8'd0);
      bus_write(A_CTRL, 8'h80);
      repeat (3) @(negedge clk);
      bus_read(A_ST0, d); chk({24'd0, d}, 32'h01, "R5 error on payload alone");
      chk(32'(cs_falls - f - 1), 32'd0, "R5 no frame on payload overflow");
      bus_write(A_CTRL, 8'h01);
   endtask

   task automatic t_busy_trigger();
      load(8'hA5, 1, 1, 4'd5, 8'h6C);
      bus_write(A_CTRL, 8'h80);
      repeat (300) @(negedge clk);
      bus_write(A_OPC, 8'h11);
      bus_write(A_CTRL, 8'h80);
      wait_idle("busy trigger");
      repeat (20) @(negedge clk);
      chk({31'd0, spi_cs_n}, 32'd1, "R7 no second frame");
      verify("R7 busy trigger");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      do_xfer(8'h9F, 0, 3, 4'd4, 8'h21, "R3 read id");
      do_xfer(8'h03, 3, 4, 4'd1, 8'h7E, "R2 read data");
      do_xfer(8'h06, 0, 0, 4'd0, 8'h00, "R2 opcode only");
      do_xfer(8'h02, 4, 67, 4'd4, 8'h33, "R5 full FIFO");
      t_overflow();
      t_busy_trigger();
      t_speed(4'd0, 3);
      t_speed(4'd1, 6);
      t_speed(4'd2, 9);
      t_speed(4'd3, 12);
      t_speed(4'd4, 2);
      t_speed(4'd5, 250);
      t_speed(4'd7, 6);
      t_speed(4'd12, 6);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule